// File: doc/BRIEF.md
# Viterbi Trace-Back Unit

This unit recovers the decoded bit sequence of a convolutionally coded block after every trellis stage has been path-extended and the survivor decisions have been stored. Each stage left one decision word in a memory outside the unit. Bit `s` of that word tells which of the two predecessor branches won at state `s`. A start command supplies the state that holds the best final path metric and the number of stages. The unit then walks the trellis backwards in one pass that covers the whole block. It reads the decision words from the newest stage to the oldest, one word per cycle.

The walk produces decoded bits newest first. The unit stores them in an internal bit buffer indexed by stage. Once the walk reaches stage 0, it streams the bits out serially, oldest stage first, so the first received symbol leaves first. A one-cycle completion pulse follows the last bit. A new command is accepted only while the unit is idle.

State numbering follows the butterfly convention: the newest input bit sits in the least significant bit of the state. The unit needs a constraint length of at least 3.

Top module: `vtb_traceback_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `done_o`, `bit_valid_o` and `dm_rd_en_o` are all 0.
- R2: After a start is accepted with N stages (N>0), `dm_rd_en_o` is high for exactly N consecutive cycles, beginning in the cycle after the accepting edge. The addresses run N-1, N-2, ... 0. Read data is expected on `dm_rd_data_i` in the cycle after the request.
- R3: The walk begins at `best_state_i`. For the current state s and the decision word of the current stage, the decoded bit of that stage is s[0]. With d = word[s], the predecessor is (s >> 1) + d * 2^(K-2).
- R4: N+1 cycles after the first read request, `bit_valid_o` is high for N consecutive cycles. `bit_o` carries the decoded bits of stages 0, 1, ... N-1 in that order, and no read is requested during that time.
- R5: With K=3, final state 0 and path decisions 1,0,1,1,0,0 from the newest stage to the oldest, the bits leave in the order 1,1,0,1,0,0.
- R6: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `done_o` is high for exactly one cycle, directly after the last valid bit.
- R7: A start while `busy_o` is high is ignored and leaves the reads, the bits and the timing of the running command unchanged.
- R8: A start with N=0 issues no reads and no bits, and `done_o` rises in the cycle after the accepting edge.
- R9: A stage count above MAX_STAGES is treated as MAX_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, taken when idle |
| best_state_i | input | K-1 | State holding the best final path metric |
| stage_count_i | input | $clog2(MAX_STAGES+1) | Number of stages in the block |
| dm_rd_en_o | output | 1 | Decision memory read request |
| dm_rd_addr_o | output | $clog2(MAX_STAGES) | Stage index to read |
| dm_rd_data_i | input | 2^(K-1) | Decision word, one cycle after the request |
| bit_valid_o | output | 1 | Decoded bit valid |
| bit_o | output | 1 | Decoded bit, oldest stage first |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with K=3 and MAX_STAGES=16. The four-state trellis makes the known six-stage decision pattern directly checkable. The small buffer lets a stage count of 20 or 31 exercise clamping in a few dozen cycles. Random decision words over full-length, short, single-stage and empty blocks drive the predecessor walk through both the high-bit and low-bit branches from every start state. A start pulse in mid-walk confirms that the running command is left alone.

// File: rtl/vtb_pkg.sv
`timescale 1ns/1ps
package vtb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACE = 2'd1,
    PH_EMIT  = 2'd2,
    PH_FIN   = 2'd3
  } vtb_phase_e;

endpackage

// File: rtl/vtb_ctrl.sv
`timescale 1ns/1ps
module vtb_ctrl
  import vtb_pkg::*;
#(
  parameter int MAX_STAGES = 64,
  parameter int IDX_W      = $clog2(MAX_STAGES),
  parameter int CNT_W      = $clog2(MAX_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] stages_i,
  output logic             load_o,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             step_o,
  output logic [IDX_W-1:0] step_idx_o,
  output logic             emit_o,
  output logic [IDX_W-1:0] emit_idx_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LIM   = CNT_W'(MAX_STAGES);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

  vtb_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] clamp;
  logic [IDX_W-1:0] iss_q, iss_d;
  logic [IDX_W-1:0] rsp_idx_q, rsp_idx_d;
  logic [IDX_W-1:0] out_q, out_d;
  logic             rsp_vld_q, rsp_vld_d;
  logic             accept, issue, last_rsp, last_out;

  assign clamp    = (stages_i > LIM) ? LIM : stages_i;
  assign accept   = (phase_q == PH_IDLE) && start_i;
  assign issue    = (phase_q == PH_TRACE) && (left_q != '0);
  assign last_rsp = rsp_vld_q && (rsp_idx_q == '0);
  assign last_out = (CNT_W'(out_q) == (len_q - ONE_C));

  // next-state process
  always_comb begin
    phase_d   = phase_q;
    len_d     = len_q;
    left_d    = left_q;
    iss_d     = iss_q;
    out_d     = out_q;
    rsp_vld_d = issue;
    rsp_idx_d = iss_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          len_d   = clamp;
          left_d  = clamp;
          iss_d   = IDX_W'(clamp - ONE_C);
          out_d   = '0;
          phase_d = (clamp == '0) ? PH_FIN : PH_TRACE;
        end
      end
      PH_TRACE: begin
        if (issue) begin
          left_d = left_q - ONE_C;
          iss_d  = iss_q - ONE_I;
        end
        if (last_rsp) begin
          phase_d = PH_EMIT;
        end
      end
      PH_EMIT: begin
        out_d = out_q + ONE_I;
        if (last_out) begin
          phase_d = PH_FIN;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      len_q     <= '0;
      left_q    <= '0;
      iss_q     <= '0;
      out_q     <= '0;
      rsp_vld_q <= 1'b0;
      rsp_idx_q <= '0;
    end else begin
      phase_q   <= phase_d;
      len_q     <= len_d;
      left_q    <= left_d;
      iss_q     <= iss_d;
      out_q     <= out_d;
      rsp_vld_q <= rsp_vld_d;
      rsp_idx_q <= rsp_idx_d;
    end
  end

  assign load_o     = accept;
  assign rd_en_o    = issue;
  assign rd_idx_o   = iss_q;
  assign step_o     = rsp_vld_q;
  assign step_idx_o = rsp_idx_q;
  assign emit_o     = (phase_q == PH_EMIT);
  assign emit_idx_o = out_q;
  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = (phase_q == PH_FIN);

  // consecutive requests walk down by one stage
  assert_rd_descend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && $past(issue)) |-> (iss_q == ($past(iss_q) - ONE_I)));

  // output streaming never overlaps memory traffic
  assert_emit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |-> (!rd_en_o && !step_o));

  // completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // a start while busy leaves the latched length alone
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (len_q == $past(len_q)));

  // latched length never exceeds the buffer depth
  assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LIM);

endmodule

// File: rtl/vtb_walk.sv
`timescale 1ns/1ps
module vtb_walk #(
  parameter int K    = 5,
  parameter int ST_W = K - 1,
  parameter int NST  = 1 << ST_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [ST_W-1:0] best_i,
  input  logic            step_i,
  input  logic [NST-1:0]  dword_i,
  output logic            bit_o
);

  logic [ST_W-1:0] cur_q, cur_d;
  logic [ST_W-1:0] pred;
  logic            dec;

  // decision bit of the current state selects the upper or lower predecessor
  assign dec   = dword_i[cur_q];
  assign pred  = {dec, cur_q[ST_W-1:1]};
  assign bit_o = cur_q[0];

  always_comb begin
    cur_d = cur_q;
    if (load_i) begin
      cur_d = best_i;
    end else if (step_i) begin
      cur_d = pred;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (load_i || step_i) begin
      cur_q <= cur_d;
    end
  end

  // the surviving state bits shift one place toward the LSB per stage
  assert_pred_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cur_q[ST_W-2:0] == $past(cur_q[ST_W-1:1])));

  // a load takes the supplied best state
  assert_load_best_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cur_q == $past(best_i)));

endmodule

// File: rtl/vtb_bitbuf.sv
`timescale 1ns/1ps
module vtb_bitbuf #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_bit_o
);

  logic [DEPTH-1:0] cell_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic en;
    assign en = wr_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[g] <= 1'b0;
      end else if (en) begin
        cell_q[g] <= wr_bit_i;
      end
    end
  end

  assign rd_bit_o = cell_q[rd_idx_i];

  // writes stay within the buffer after clamping
  assert_wr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> (int'(wr_idx_i) < DEPTH));

  // a written cell holds the written bit
  assert_wr_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cell_q[$past(wr_idx_i)] == $past(wr_bit_i)));

endmodule

// File: rtl/vtb_traceback_unit.sv
`timescale 1ns/1ps
module vtb_traceback_unit #(
  parameter int K          = 5,
  parameter int MAX_STAGES = 64,
  parameter int ST_W       = K - 1,
  parameter int NST        = 1 << ST_W,
  parameter int IDX_W      = $clog2(MAX_STAGES),
  parameter int CNT_W      = $clog2(MAX_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ST_W-1:0]  best_state_i,
  input  logic [CNT_W-1:0] stage_count_i,
  output logic             dm_rd_en_o,
  output logic [IDX_W-1:0] dm_rd_addr_o,
  input  logic [NST-1:0]   dm_rd_data_i,
  output logic             bit_valid_o,
  output logic             bit_o,
  output logic             busy_o,
  output logic             done_o
);

  logic             load, step, emit, walk_bit;
  logic [IDX_W-1:0] step_idx, emit_idx;

  vtb_ctrl #(
    .MAX_STAGES(MAX_STAGES),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stages_i  (stage_count_i),
    .load_o    (load),
    .rd_en_o   (dm_rd_en_o),
    .rd_idx_o  (dm_rd_addr_o),
    .step_o    (step),
    .step_idx_o(step_idx),
    .emit_o    (emit),
    .emit_idx_o(emit_idx),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  vtb_walk #(
    .K   (K),
    .ST_W(ST_W),
    .NST (NST)
  ) walk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .best_i (best_state_i),
    .step_i (step),
    .dword_i(dm_rd_data_i),
    .bit_o  (walk_bit)
  );

  vtb_bitbuf #(
    .DEPTH(MAX_STAGES),
    .IDX_W(IDX_W)
  ) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (step),
    .wr_idx_i(step_idx),
    .wr_bit_i(walk_bit),
    .rd_idx_i(emit_idx),
    .rd_bit_o(bit_o)
  );

  assign bit_valid_o = emit;

  // done only while a command is in progress
  assert_done_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // no memory or output traffic while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!dm_rd_en_o && !bit_valid_o));

endmodule

// File: tb/vtb_traceback_unit_tb.sv
`timescale 1ns/1ps
module vtb_traceback_unit_tb_top;

  localparam int K     = 3;
  localparam int MAXS  = 16;
  localparam int ST_W  = K - 1;
  localparam int NST   = 1 << ST_W;
  localparam int IDX_W = $clog2(MAXS);
  localparam int CNT_W = $clog2(MAXS + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [ST_W-1:0]  best = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic             rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic [NST-1:0]   rd_data = '0;
  logic             bv, b, busy, done;

  always #2.5 clk = ~clk;

  vtb_traceback_unit #(.K(K), .MAX_STAGES(MAXS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .best_state_i(best),
    .stage_count_i(cnt), .dm_rd_en_o(rd_en), .dm_rd_addr_o(rd_addr),
    .dm_rd_data_i(rd_data), .bit_valid_o(bv), .bit_o(b),
    .busy_o(busy), .done_o(done)
  );

  // decision memory with one cycle read latency
  logic [NST-1:0] mem [MAXS];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int    nchk = 0;
  int    nfail = 0;
  bit    ended = 0;
  string tag = "";
  logic [15:0] cap = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  // behavioural reference: a cycle counter per command plus expected bits
  bit m_act = 0;
  int mk = 0, mN = 0, mlast = 0;
  bit eb [MAXS];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0;
    end else if (m_act) begin
      if (mk == mlast) m_act = 0;
      else mk = mk + 1;
    end else if (start) begin
      int s;
      mN = (int'(cnt) > MAXS) ? MAXS : int'(cnt);
      mlast = (mN == 0) ? 0 : 2 * mN + 1;
      mk = 0;
      m_act = 1;
      s = int'(best);
      for (int j = mN - 1; j >= 0; j--) begin
        int d;
        eb[j] = s[0];
        d = int'(mem[j][s]);
        s = (s >> 1) + d * (1 << (K - 2));
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      bit e_rd, e_v, e_done;
      e_done = m_act && (mk == mlast);
      e_rd   = m_act && (mN > 0) && (mk < mN);
      e_v    = m_act && (mN > 0) && (mk >= mN + 1) && (mk <= 2 * mN);
      check(busy == m_act, "R6 busy", int'(busy), int'(m_act));
      check(done == e_done, "R6 done", int'(done), int'(e_done));
      check(rd_en == e_rd, "R2 rd_en", int'(rd_en), int'(e_rd));
      if (e_rd) check(int'(rd_addr) == mN - 1 - mk, "R2 addr", int'(rd_addr), mN - 1 - mk);
      check(bv == e_v, "R4 valid", int'(bv), int'(e_v));
      if (e_v) check(b == eb[mk - mN - 1], "R3 bit", int'(b), int'(eb[mk - mN - 1]));
      if (bv) cap = {cap[14:0], b};
    end
  end

  task automatic finish_up();
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic run_blk(input int bs, input int n);
    @(negedge clk);
    start = 1'b1;
    best  = ST_W'(bs);
    cnt   = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill_random();
    for (int i = 0; i < MAXS; i++) mem[i] = NST'($urandom);
  endtask

  task automatic set_path(input int j, input int s, input int d);
    logic [NST-1:0] w;
    w = d[0] ? '0 : '1;
    w[s] = d[0];
    mem[j] = w;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    for (int i = 0; i < MAXS; i++) mem[i] = '0;
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    tag = "reset";
    check(!busy && !done && !bv && !rd_en, "R1 during reset", int'({busy, done, bv, rd_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !bv && !rd_en, "R1 after reset", int'({busy, done, bv, rd_en}), 0);

    // R5: known six-stage path ending in state 0
    tag = "R5 example";
    set_path(0, 1, 0);
    set_path(1, 3, 0);
    set_path(2, 2, 1);
    set_path(3, 1, 1);
    set_path(4, 2, 0);
    set_path(5, 0, 1);
    cap = '0;
    run_blk(0, 6);
    check(cap[5:0] == 6'b110100, "R5 sequence", int'(cap[5:0]), int'(6'b110100));

    // R3/R4: random decisions from every start state, several lengths
    tag = "R3 random full";
    for (int r = 0; r < NST; r++) begin
      fill_random();
      run_blk(r, MAXS);
    end
    tag = "R4 short";
    fill_random();
    run_blk(3, 5);
    run_blk(1, 1);
    run_blk(2, 2);

    // R8: empty block
    tag = "R8 empty";
    run_blk(1, 0);

    // R9: counts beyond the buffer depth
    tag = "R9 clamp";
    fill_random();
    run_blk(2, 20);
    run_blk(1, 31);

    // R7: start pulse while busy is ignored
    tag = "R7 busy start";
    fill_random();
    @(negedge clk);
    start = 1'b1;
    best  = 2'd3;
    cnt   = CNT_W'(9);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    best  = 2'd0;
    cnt   = CNT_W'(4);
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_act) @(negedge clk);
    repeat (2) @(negedge clk);
    check(!busy, "R7 idle after ignored starts", int'(busy), 0);

    finish_up();
  end

endmodule